// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block keeps a rolling record of a 32-bit trace word stream in an on-chip ring memory. Capture begins at the slot named by a software-set write pointer. Each accepted word lands in the next slot. Once the ring has wrapped, new words overwrite the oldest ones. The memory therefore always holds the most recent history rather than everything since capture began.

Capture ends in one of two ways. Software can clear the run bit. Or a trigger pulse arrives, and the block stores a programmed number of further words and then halts by itself. Once halted, the history can be read out in two ways. Software can pull it one word per access through a read-data register. Or a drain command streams every valid word, oldest first, out of a valid/ready port.

All configuration registers are guarded by a key gate. Writes have no effect until a magic value has been written to the key register.

Top module: `trace_ring_buffer`

## Requirements
- R1: After reset the block is locked (key register reads 1) and capture is off. The status register reads 3: bit0 ready=1, bit1 empty=1, bit2 wrapped=0, bit3 triggered=0. The write pointer (address 3) and the post-trigger count (address 5) both read 0.
- R2: While locked, writes to any register other than the key register (address 7) are ignored. Writing 32'hC5ACCE55 to address 7 unlocks the block. Writing any other value to address 7 locks it again.
- R3: Writing 1 to bit0 of the control register (address 0) starts capture at the current write pointer. Each cycle with trc_valid high while capture runs stores one word and advances the write pointer by one, modulo DEPTH.
- R4: Starting capture sets status bit1 (empty). The first stored word clears it.
- R5: When the write pointer comes back round to the start slot, status bit2 (wrapped) is set and later words overwrite the oldest ones. On halt, the read pointer (address 4) is placed at the oldest surviving word. That is the write pointer if the ring has wrapped, and the start slot otherwise.
- R6: The first trc_trigger pulse during capture sets status bit3. Capture then halts after exactly the number of further words held in address 5. A count of 0 halts in the trigger cycle itself, and a word offered in that same cycle is still stored. Words offered after the halt are not stored and do not move the write pointer.
- R7: Reading the read-data register (address 2) returns 32'hFFFFFFFF, and leaves the read pointer unchanged, while capture runs, while a drain is active, or while the buffer is empty.
- R8: After a halt, each read of address 2 returns the word at the read pointer and advances the read pointer by one.
- R9: Writing 1 to bit0 of the drain register (address 6) while halted and not empty streams all valid words, oldest first, on dout_data. A word moves only in a cycle where dout_valid and dout_ready are both high. When the drain ends, the status register shows empty=1 and wrapped=0.
- R10: Status bit0 (ready) is 1 exactly when capture is off and no drain is active.
- R11: Writing 0 to bit0 of address 0 while capture runs halts it. This has the same read pointer placement as a trigger halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trc_valid | input | 1 | Trace word present this cycle |
| trc_data | input | DW | Trace word |
| trc_trigger | input | 1 | Trigger pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only for address 2) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dout_valid | output | 1 | Drain word valid |
| dout_ready | input | 1 | Drain sink ready |
| dout_data | output | DW | Drain word |

## Verification
The first pattern is a short run with no wrap that is halted by software. It shows whether read-out starts at the start slot and whether reads step through the words in order. The second pattern overruns a 16-deep ring and then triggers with a count of two. It separates correct oldest-first ordering and overwrite from off-by-one errors in the post-trigger count. The third pattern triggers with a count of zero while a word is offered in the same cycle. It also drains the result into a stalled sink, which exposes errors in the halt timing and in the ready flag during a drain. A scoreboard compares every drained word against the order expected from the stimulus.

// File: rtl/trace_ring_buffer.sv
module trace_ring_buffer #(
  parameter int DW = 32,
  parameter int DEPTH = 1024,
  parameter int CNT_W = 16,
  parameter logic [31:0] KEY = 32'hC5ACCE55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trc_valid,
  input  logic [DW-1:0] trc_data,
  input  logic          trc_trigger,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          dout_valid,
  input  logic          dout_ready,
  output logic [DW-1:0] dout_data
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_RDAT = 3'd2, A_WPTR = 3'd3,
                         A_RPTR = 3'd4, A_TCNT = 3'd5, A_DRN = 3'd6, A_KEY = 3'd7;

  logic [DW-1:0] mem [DEPTH];
  logic locked, cap_en, trig_seen, full, empty, draining;
  logic [AW-1:0] wptr, rptr, base, dptr;
  logic [AW:0] dcnt;
  logic [CNT_W-1:0] trgcnt, remain;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire wr_ok   = reg_wr && !locked;
  wire store   = cap_en && trc_valid;
  wire trig_now = cap_en && trc_trigger && !trig_seen;
  wire stop_trig = (trig_now && trgcnt == '0) ||
                   (cap_en && trig_seen && store && remain == CNT_W'(1));
  wire sw_stop = wr_ok && reg_addr == A_CTRL && !reg_wdata[0] && cap_en;
  wire stop    = stop_trig || sw_stop;
  wire start   = wr_ok && reg_addr == A_CTRL && reg_wdata[0] && !cap_en && !draining;
  wire ready   = !cap_en && !draining;
  wire rd_ok   = ready && !empty;
  wire rd_fire = reg_rd && reg_addr == A_RDAT && rd_ok;
  wire drn_go  = wr_ok && reg_addr == A_DRN && reg_wdata[0] && rd_ok;
  wire drn_hs  = draining && dout_ready;

  wire [AW-1:0] wnext  = nxt(wptr);
  wire [AW-1:0] wptr_n = store ? wnext : wptr;
  wire          full_n = full || (store && wnext == base);
  wire [AW-1:0] oldest = full ? wptr : base;
  wire [AW:0]   used   = full ? (AW+1)'(DEPTH) :
                         ({1'b0, wptr} >= {1'b0, base}) ? {1'b0, wptr} - {1'b0, base} :
                         {1'b0, wptr} + (AW+1)'(DEPTH) - {1'b0, base};

  always_ff @(posedge clk)
    if (store) mem[wptr] <= trc_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b1; cap_en <= 1'b0; trig_seen <= 1'b0; full <= 1'b0;
      empty <= 1'b1; draining <= 1'b0; wptr <= '0; rptr <= '0; base <= '0;
      dptr <= '0; dcnt <= '0; trgcnt <= '0; remain <= '0;
    end else begin
      if (reg_wr && reg_addr == A_KEY) locked <= (reg_wdata != KEY);
      if (wr_ok && reg_addr == A_TCNT) trgcnt <= reg_wdata[CNT_W-1:0];

      if (start) begin
        cap_en <= 1'b1; trig_seen <= 1'b0; full <= 1'b0; empty <= 1'b1; base <= wptr;
      end else begin
        if (store) begin
          wptr <= wptr_n; full <= full_n; empty <= 1'b0;
        end else if (wr_ok && reg_addr == A_WPTR && !cap_en) begin
          wptr <= reg_wdata[AW-1:0];
        end
        if (trig_now) begin
          trig_seen <= 1'b1; remain <= trgcnt;
        end else if (trig_seen && store) begin
          remain <= remain - 1'b1;
        end
        if (stop) begin
          cap_en <= 1'b0;
          rptr <= full_n ? wptr_n : base;
        end else if (rd_fire) begin
          rptr <= nxt(rptr);
        end else if (wr_ok && reg_addr == A_RPTR && ready) begin
          rptr <= reg_wdata[AW-1:0];
        end
      end

      if (drn_go) begin
        draining <= 1'b1; dptr <= oldest; dcnt <= used;
      end else if (drn_hs) begin
        dptr <= nxt(dptr);
        dcnt <= dcnt - 1'b1;
        if (dcnt == (AW+1)'(1)) begin
          draining <= 1'b0; empty <= 1'b1; full <= 1'b0;
        end
      end
    end
  end

  assign dout_valid = draining;
  assign dout_data  = mem[dptr];

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {31'b0, cap_en};
      A_STAT:  reg_rdata = {28'b0, trig_seen, full, empty, ready};
      A_RDAT:  reg_rdata = rd_ok ? 32'(mem[rptr]) : 32'hFFFF_FFFF;
      A_WPTR:  reg_rdata = 32'(wptr);
      A_RPTR:  reg_rdata = 32'(rptr);
      A_TCNT:  reg_rdata = 32'(trgcnt);
      A_DRN:   reg_rdata = {31'b0, draining};
      default: reg_rdata = {31'b0, locked};
    endcase
  end

  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && reg_wr && reg_addr == A_TCNT) |=> $stable(trgcnt)); // R2
  AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && trc_valid) |=> !empty); // R4
  AST_WPTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !(wr_ok && reg_addr == A_WPTR)) |=> $stable(wptr)); // R6
  AST_RUN_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && reg_rd && reg_addr == A_RDAT && !reg_wr) |=> $stable(rptr)); // R7
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data))); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_STAT && reg_rdata[0]) |-> (!dout_valid && !cap_en)); // R10
endmodule

// File: tb/sim_trace_ring_buffer.sv
module sim_trace_ring_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trc_valid = 1'b0, trc_trigger = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, dout_ready = 1'b0;
  logic [31:0] trc_data = '0, reg_wdata = '0, reg_rdata, dout_data;
  logic [2:0] reg_addr = '0;
  logic dout_valid;
  int checks = 0, failures = 0, cyc = 0, drained = 0;
  bit hold = 1'b0;
  logic [31:0] exp_q [$];

  trace_ring_buffer #(.DW(32), .DEPTH(DEPTH), .CNT_W(16)) u0 (
    .clk, .rst_n, .trc_valid, .trc_data, .trc_trigger, .reg_wr, .reg_rd, .reg_addr,
    .reg_wdata, .reg_rdata, .dout_valid, .dout_ready, .dout_data);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic push(input logic [31:0] d, input bit trig);
    @(negedge clk); trc_valid = 1'b1; trc_data = d; trc_trigger = trig;
    @(posedge clk); #1 trc_valid = 1'b0; trc_trigger = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trc_trigger = 1'b1;
    @(posedge clk); #1 trc_trigger = 1'b0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 500 && (exp_q.size() != 0 || dout_valid); i++) @(negedge clk);
  endtask

  always @(negedge clk) begin
    cyc++;
    dout_ready = !hold && (cyc % 3 != 1);
    if (dout_valid && dout_ready) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R9 unexpected drain word actual=%h expected=none", dout_data);
      end else begin
        check("R9 drain order", dout_data, exp_q.pop_front());
        drained++;
      end
    end
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(3'd1, v); check("R1 status", v, 32'd3);
    rd(3'd7, v); check("R1 locked", v, 32'd1);
    rd(3'd3, v); check("R1 wptr", v, 32'd0);
    rd(3'd5, v); check("R1 trgcnt", v, 32'd0);

    wr(3'd5, 32'd5); rd(3'd5, v); check("R2 locked write", v, 32'd0);
    wr(3'd7, 32'hC5ACCE55); rd(3'd7, v); check("R2 unlock", v, 32'd0);
    wr(3'd5, 32'd5); rd(3'd5, v); check("R2 unlocked write", v, 32'd5);
    wr(3'd7, 32'd0); wr(3'd5, 32'd9); rd(3'd5, v); check("R2 relock", v, 32'd5);
    wr(3'd7, 32'hC5ACCE55);

    wr(3'd5, 32'd100);
    wr(3'd3, 32'd3); wr(3'd0, 32'd1);
    rd(3'd1, v); check("R4 empty at start", v, 32'd2);
    push(32'hA000, 1'b0);
    rd(3'd1, v); check("R4 empty cleared", v, 32'd0);
    rd(3'd2, v); check("R7 read while running", v, 32'hFFFF_FFFF);
    rd(3'd4, v); check("R7 rptr unchanged", v, 32'd0);
    for (int i = 1; i < 5; i++) push(32'hA000 + i, 1'b0);
    rd(3'd3, v); check("R3 wptr advance", v, 32'd8);
    wr(3'd0, 32'd0);
    rd(3'd1, v); check("R11 halted ready", v, 32'd1);
    rd(3'd4, v); check("R11 rptr at start slot", v, 32'd3);
    for (int i = 0; i < 5; i++) begin
      rd(3'd2, v); check("R8 read-out word", v, 32'hA000 + i);
    end
    rd(3'd4, v); check("R8 rptr advanced", v, 32'd8);
    push(32'hDEAD, 1'b0);
    rd(3'd3, v); check("R6 no store when halted", v, 32'd8);

    wr(3'd5, 32'd2); wr(3'd3, 32'd0); wr(3'd0, 32'd1);
    for (int i = 0; i < 20; i++) push(32'h1000 + i, 1'b0);
    pulse_trig();
    for (int i = 0; i < 5; i++) push(32'h2000 + i, 1'b0);
    rd(3'd1, v); check("R6 trigger halt status (R5 wrapped)", v, 32'd13);
    rd(3'd3, v); check("R6 exact post-trigger count", v, 32'd6);
    rd(3'd4, v); check("R5 rptr at oldest", v, 32'd6);
    rd(3'd2, v); check("R5 oldest word", v, 32'h1006);
    rd(3'd2, v); check("R5 next word", v, 32'h1007);
    for (int i = 6; i < 20; i++) exp_q.push_back(32'h1000 + i);
    exp_q.push_back(32'h2000); exp_q.push_back(32'h2001);
    drained = 0;
    wr(3'd6, 32'd1);
    wait_drain();
    check("R9 drained count", drained, 32'd16);
    rd(3'd1, v); check("R9 status after drain", v, 32'd11);

    wr(3'd5, 32'd0); wr(3'd3, 32'd0); wr(3'd0, 32'd1);
    for (int i = 0; i < 3; i++) push(32'h3000 + i, 1'b0);
    push(32'h3003, 1'b1);
    push(32'h3004, 1'b0);
    rd(3'd3, v); check("R6 zero count halts on trigger", v, 32'd4);
    rd(3'd0, v); check("R6 capture off", v, 32'd0);
    hold = 1'b1;
    for (int i = 0; i < 4; i++) exp_q.push_back(32'h3000 + i);
    drained = 0;
    wr(3'd6, 32'd1);
    rd(3'd1, v); check("R10 not ready while draining", v[0], 1'b0);
    rd(3'd2, v); check("R7 read while draining", v, 32'hFFFF_FFFF);
    check("R9 stalled sink no word", drained, 32'd0);
    hold = 1'b0;
    wait_drain();
    check("R9 drained count zero-trigger", drained, 32'd4);
    rd(3'd1, v); check("R10 ready after drain", v[0], 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule